// File: doc/BRIEF.md
# Counted Configuration Clock Burst Generator

This block produces a counted burst of configuration clock pulses on demand. Software writes a pulse count into the count register. The block then drives that many pulses on `dclk_o` and latches a completion flag. Software clears the flag by writing one to it. A typical use is the short run of extra clocks that follows a configuration load; a count of 4 is common there.

The width of each pulse is a parameter. Every pulse stays high for `HALF_DIV` system clock cycles and then low for `HALF_DIV` cycles. The output rests low whenever no burst is running. A status register reports completion and activity. The count register reads back how many pulses are still to come.

A single-cycle write strobe and a shared address drive the register port. Reads are combinational from the same address.

Top module: `cfgclk_burst_gen`

## Requirements
- R1: A write to address 0x8 with a nonzero value N, accepted while idle, raises `dclk_o` in the cycle right after the write edge and produces exactly N high pulses.
- R2: Each pulse is high for `HALF_DIV` cycles and then low for `HALF_DIV` cycles. `dclk_o` is low whenever no burst is active.
- R3: Bit 0 of the status register at address 0xc, mirrored on `done_o`, becomes 1 exactly 2·N·`HALF_DIV` cycles after the write edge that started the burst. It stays 0 until then.
- R4: A write to 0xc with data bit 0 equal to 1 clears the done bit. A write with bit 0 equal to 0 leaves it unchanged.
- R5: A count write of 0, accepted while idle, sets the done bit at the write edge. It produces no pulse and never sets busy.
- R6: A count write is ignored, with no change to the pulse train, the count or the status, while a burst is active or while the done bit is still set.
- R7: Bit 1 of the status register (busy) is 1 from the accepting write edge until the edge that sets done. Status bits above bit 1 read 0.
- R8: Address 0x8 reads the number of pulses remaining. It holds N after the start and drops by one at each falling edge of `dclk_o`, so it reads 0 at completion.
- R9: After reset `dclk_o` is 0, `done_o` is 0, the status reads 0 and the count reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| dclk_o | output | 1 | Configuration clock pulse output, idles low |
| done_o | output | 1 | Completion flag, same as status bit 0 |

## Verification
A write edge E changes registered state, so the bench samples every result on the falling clock edge that follows E.

The expected timing for each burst is as follows:
- The pulse is high in samples E..E+H−1 and low in samples E+H..E+2H−1 of each period.
- The count drops at sample E+H(2k+1).
- Done and the clearing of busy are due at sample E+2NH.

A zero count sets done at sample E itself. A clear write takes effect at the sample after its edge.

The bench walks each burst one sample at a time against these cycle numbers. Every pulse level, count readback and status word is compared exactly in the cycle it is due, never within a window.

// File: rtl/cfgclk_pkg.sv
// Package: shared register offsets and status bit positions for the
// configuration clock burst generator. Offsets are the software-visible
// decode and must not move.
package cfgclk_pkg;
    localparam int unsigned CNT_OFS      = 32'h8;  // pulse count / remaining
    localparam int unsigned STAT_OFS     = 32'hC;  // status (done W1C, busy RO)
    localparam int unsigned STAT_DONE_B  = 0;      // completion flag bit
    localparam int unsigned STAT_BUSY_B  = 1;      // burst-active bit
endpackage

// File: rtl/cfgclk_half_timer.sv
// Module: cfgclk_half_timer
// Counts system clock cycles within one half period of the output clock and
// flags the last cycle of each half period.
// Assumes HALF_DIV >= 1; restart and idle both force the count to zero.
module cfgclk_half_timer #(
    parameter int unsigned HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_q;

    // Last cycle of the current half period.
    assign tick = run && (cnt_q == LAST);

    // Half-period cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgclk_pulse_seq.sv
// Module: cfgclk_pulse_seq
// Holds the remaining pulse count and shapes the output clock level.
// On start with a nonzero load it raises the clock at once. At each half-period
// tick it toggles the level. The count drops on every falling transition, and
// the burst ends after the low half of the last pulse.
// Assumes start is only asserted while idle (gated upstream).
module cfgclk_pulse_seq #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_cnt,
    input  logic             tick,
    output logic             busy,
    output logic             dclk,
    output logic [CNT_W-1:0] remain,
    output logic             finish
);
    logic             busy_q;
    logic             dclk_q;
    logic [CNT_W-1:0] remain_q;
    logic             load_zero;
    logic             last_low;

    assign load_zero = (load_cnt == '0);
    assign last_low  = busy_q && tick && !dclk_q && (remain_q == '0);

    // Completion: either an empty request or the end of the last low half.
    assign finish = (start && load_zero) || last_low;

    // Burst state, output level and remaining count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            dclk_q   <= 1'b0;
            remain_q <= '0;
        end else if (start && !load_zero) begin
            busy_q   <= 1'b1;
            dclk_q   <= 1'b1;
            remain_q <= load_cnt;
        end else if (busy_q && tick) begin
            if (dclk_q) begin
                dclk_q   <= 1'b0;
                remain_q <= remain_q - 1'b1;
            end else if (remain_q == '0) begin
                busy_q   <= 1'b0;
            end else begin
                dclk_q   <= 1'b1;
            end
        end
    end

    assign busy   = busy_q;
    assign dclk   = dclk_q;
    assign remain = remain_q;
endmodule

// File: rtl/cfgclk_regs.sv
// Module: cfgclk_regs
// Decodes register writes, holds the write-one-to-clear done flag and muxes
// read data. A count write is accepted only when no burst runs and done is
// clear. Set has priority over clear, though the gating keeps them apart.
// Assumes ADDR_W >= 4 so that both offsets are reachable.
module cfgclk_regs
    import cfgclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] remain,
    input  logic              finish,
    output logic              start,
    output logic [DATA_W-1:0] load_cnt,
    output logic              done,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic done_q;
    logic clr_req;

    // Count write accepted only from a fully idle state.
    assign start    = reg_wr && (reg_addr == CNT_A) && !busy && !done_q;
    assign load_cnt = reg_wdata;
    assign clr_req  = reg_wr && (reg_addr == STAT_A) && reg_wdata[STAT_DONE_B];

    // Sticky completion flag with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (finish) begin
            done_q <= 1'b1;
        end else if (clr_req) begin
            done_q <= 1'b0;
        end
    end

    // Read data mux.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == CNT_A) begin
            reg_rdata = remain;
        end else if (reg_addr == STAT_A) begin
            reg_rdata[STAT_DONE_B] = done_q;
            reg_rdata[STAT_BUSY_B] = busy;
        end
    end

    assign done = done_q;
endmodule

// File: rtl/cfgclk_burst_gen.sv
// Module: cfgclk_burst_gen (top)
// Counted configuration clock burst generator: a register write of N emits N
// pulses of HALF_DIV cycles high and HALF_DIV low, then latches done.
// Assumes a single-cycle write strobe and synchronous active-low reset.
module cfgclk_burst_gen #(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              dclk_o,
    output logic              done_o
);
    logic              start_w;
    logic [DATA_W-1:0] load_w;
    logic              busy_w;
    logic [DATA_W-1:0] remain_w;
    logic              finish_w;
    logic              tick_w;

    cfgclk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy_w),
        .remain    (remain_w),
        .finish    (finish_w),
        .start     (start_w),
        .load_cnt  (load_w),
        .done      (done_o),
        .reg_rdata (reg_rdata)
    );

    cfgclk_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (start_w),
        .run     (busy_w),
        .tick    (tick_w)
    );

    cfgclk_pulse_seq #(.CNT_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_w),
        .load_cnt (load_w),
        .tick     (tick_w),
        .busy     (busy_w),
        .dclk     (dclk_o),
        .remain   (remain_w),
        .finish   (finish_w)
    );
endmodule

// File: rtl/cfgclk_burst_chk.sv
// Module: cfgclk_burst_chk
// Temporal properties of the burst generator, bound to the top module.
module cfgclk_burst_chk
    import cfgclk_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              dclk_o,
    input logic              done_o,
    input logic              busy,
    input logic [DATA_W-1:0] remain
);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFS);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

    logic cnt_wr;
    logic clr_wr;
    assign cnt_wr = reg_wr && (reg_addr == CNT_A);
    assign clr_wr = reg_wr && (reg_addr == STAT_A) && reg_wdata[STAT_DONE_B];

    p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !busy && !done_o && reg_wdata != '0)
        |=> (busy && dclk_o && remain == $past(reg_wdata)));

    p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dclk_o);

    p_done_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (!busy && !dclk_o && remain == '0));

    p_done_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_wr) |=> done_o);

    p_done_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && clr_wr) |=> !done_o);

    p_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && !busy && !done_o && reg_wdata == '0) |=> (done_o && !busy));

    p_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && (busy || done_o)) |=> (remain <= $past(remain)));

    p_fall_dec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dclk_o) |-> (remain == $past(remain) - 1'b1));
endmodule

bind cfgclk_burst_gen cfgclk_burst_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .dclk_o    (dclk_o),
    .done_o    (done_o),
    .busy      (busy_w),
    .remain    (remain_w)
);

// File: tb/test_cfgclk_burst_gen.sv
// Directed bench for cfgclk_burst_gen: one task per scenario.
module test_cfgclk_burst_gen;
    localparam int unsigned AW = 4;
    localparam int unsigned DW = 32;
    localparam int unsigned H  = 2;
    localparam logic [AW-1:0] A_CNT  = 4'h8;
    localparam logic [AW-1:0] A_STAT = 4'hC;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          dclk_o;
    logic          done_o;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfgclk_burst_gen #(.ADDR_W(AW), .DATA_W(DW), .HALF_DIV(H)) i_cfgclk_burst_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dclk_o(dclk_o), .done_o(done_o)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        chk("R9 dclk after reset", DW'(dclk_o), 0);
        chk("R9 done after reset", DW'(done_o), 0);
        rd(A_STAT, d); chk("R9 status after reset", d, 0);
        rd(A_CNT, d);  chk("R9 count after reset", d, 0);
    endtask

    task automatic t_burst(input int n);
        logic [DW-1:0] d;
        wr(A_CNT, DW'(n));
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < H; j++) begin
                chk("R1/R2 high phase", DW'(dclk_o), 1);
                rd(A_CNT, d);  chk("R8 remaining in high phase", d, DW'(n - k));
                rd(A_STAT, d); chk("R7 busy, R3 not done", d, 32'h2);
                @(negedge clk);
            end
            for (int j = 0; j < H; j++) begin
                chk("R2 low phase", DW'(dclk_o), 0);
                rd(A_CNT, d);  chk("R8 remaining in low phase", d, DW'(n - k - 1));
                rd(A_STAT, d); chk("R7 busy, R3 not done", d, 32'h2);
                @(negedge clk);
            end
        end
        chk("R3 done at 2*N*H", DW'(done_o), 1);
        rd(A_STAT, d); chk("R7 busy cleared at done", d, 32'h1);
        rd(A_CNT, d);  chk("R8 count zero at end", d, 0);
        chk("R2 idle low after burst", DW'(dclk_o), 0);
        wr(A_STAT, 32'h1);
        chk("R4 clear done", DW'(done_o), 0);
    endtask

    task automatic t_clear_zero_write();
        logic [DW-1:0] d;
        wr(A_CNT, 0);
        chk("R5 zero count done", DW'(done_o), 1);
        rd(A_STAT, d); chk("R5 zero count not busy", d, 32'h1);
        for (int i = 0; i < 4; i++) begin
            chk("R5 no pulse", DW'(dclk_o), 0);
            @(negedge clk);
        end
        wr(A_STAT, 32'hFFFF_FFFE);
        chk("R4 write of 0 keeps done", DW'(done_o), 1);
        wr(A_STAT, 32'h1);
        chk("R4 write of 1 clears done", DW'(done_o), 0);
    endtask

    task automatic t_ignore_busy();
        int rises = 0;
        bit prev = 1'b0;
        logic [DW-1:0] d;
        wr(A_CNT, 5);
        for (int i = 0; i < 200; i++) begin
            if (dclk_o && !prev) rises++;
            prev = dclk_o;
            if (done_o) break;
            if (i == 1) begin
                reg_wr = 1'b1; reg_addr = A_CNT; reg_wdata = 9;
            end else begin
                reg_wr = 1'b0; reg_wdata = '0;
            end
            @(negedge clk);
        end
        chk("R6 write during burst ignored, pulses", DW'(rises), 5);
        rd(A_CNT, d); chk("R6 count after ignored write", d, 0);
    endtask

    task automatic t_ignore_done();
        logic [DW-1:0] d;
        chk("R6 done still set", DW'(done_o), 1);
        wr(A_CNT, 3);
        for (int i = 0; i < 6; i++) begin
            chk("R6 no pulse while done set", DW'(dclk_o), 0);
            @(negedge clk);
        end
        rd(A_STAT, d); chk("R6 status unchanged", d, 32'h1);
        rd(A_CNT, d);  chk("R6 count unchanged", d, 0);
        wr(A_STAT, 32'h1);
        chk("R4 clear after ignored write", DW'(done_o), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_burst(4);
        t_burst(1);
        t_burst(3);
        t_clear_zero_write();
        t_ignore_busy();
        t_ignore_done();
        t_burst(2);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule